// File: doc/BRIEF.md
# Video DRAM Random-Port Cycle Decoder

This block models the random-access side of a dual-port video memory as synchronous logic. It runs on a fast system clock and oversamples the active-low row strobe, column strobe, transfer/output-enable strobe, the two byte write enables and the special-function select. From these it decides what each memory cycle means. A register holds the previous strobe levels, and a falling strobe edge is seen on the first clock where the sampled level is low and the held level is high.

The cycle type is fixed on the row-strobe falling edge. It can be a plain access, a write-per-bit access with a mask taken from the data pins, a write-per-bit access with a stored mask, a register load, a transfer to the serial side, or a refresh. Each later column-strobe falling edge inside the same row cycle performs one access, so page mode works. A read drives the data-output enable. A write applies byte enables and bit masks to a small internal array, and a block write stores the color register in four aligned columns at once.

A transfer cycle does not touch the array. It produces a request for the serial port that carries the row, the start tap and a split flag. The request uses a valid/ready handshake. While valid is high and ready is low, the request and its fields are held unchanged. Any transfer cycle that completes while a request is still pending, including the cycle in which the pending request is accepted, is dropped.

Top module: `vdram_rport`

## Requirements
- R1: After reset, `dq_oe` and `xfer_valid` are 0, the stored bit mask is all ones and the color register is zero.
- R2: On a row-strobe fall, a low column strobe marks a refresh cycle and a low `trg_n` marks a transfer cycle. Neither type writes the array or raises `dq_oe`, even when the write enables and `trg_n` are low.
- R3: In an access cycle, a column-strobe fall with both write enables high reads the word at {row, column}. That word appears on `dq_out` from the next clock on.
- R4: A write at a column-strobe fall changes bits 7:0 only if `wel_n` is 0 and bits 15:8 only if `weu_n` is 0.
- R5: If a write enable is low and `dsf` is 0 at the row-strobe fall, `dq_in` at that edge becomes the cycle's bit mask. A mask bit of 1 lets the data bit be written and a mask bit of 0 keeps the stored bit.
- R6: If a write enable is low and `dsf` is 1 at the row-strobe fall, the stored mask register is the bit mask for every write in that cycle, and it stays in force across cycles until it is reloaded.
- R7: A row-strobe fall with `trg_n` high, both write enables high and `dsf` 1 starts a register load. At the column-strobe fall, `dsf` 0 loads `dq_in` into the mask register and `dsf` 1 loads it into the color register.
- R8: A write with `dsf` 1 at the column-strobe fall is a block write. It writes the color register into the four columns whose addresses differ only in bits 1:0, and the byte and bit masks still apply.
- R9: `dq_oe` is 1 only after a read access, and only while both the column strobe and `trg_n` are low.
- R10: In a transfer cycle, the column-strobe fall raises `xfer_valid`. `xfer_row` then holds the 9-bit address latched at the row-strobe fall, `xfer_tap` holds the 9-bit address at the column-strobe fall, and `xfer_split` holds `dsf` as sampled at the row-strobe fall.
- R11: While `xfer_valid` is 1 and `xfer_ready` is 0, the request fields do not change. A transfer cycle that completes while a request is pending is dropped. The request clears on the clock after `xfer_ready` is seen high.
- R12: Several column-strobe falls within one row cycle each perform an access. A column-strobe fall while the row strobe is high accesses nothing, and `dq_oe` is 0 on the clock after a high row strobe is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| trg_n | input | 1 | Transfer select at row fall, output enable afterwards |
| wel_n | input | 1 | Write enable, low byte |
| weu_n | input | 1 | Write enable, high byte |
| dsf | input | 1 | Special-function select |
| addr | input | 9 | Multiplexed row/column address |
| dq_in | input | 16 | Data and mask input |
| dq_out | output | 16 | Read data |
| dq_oe | output | 1 | Read data output enable |
| xfer_valid | output | 1 | Transfer request valid |
| xfer_ready | input | 1 | Serial port accepts the request |
| xfer_row | output | 9 | Row address of the transfer |
| xfer_tap | output | 9 | Serial start tap |
| xfer_split | output | 1 | Split-register transfer flag |

## Verification
If the block misclassifies a cycle or holds a stale mask or color value, the error shows up on the clock after the next read column-strobe fall. At that point `dq_out` or `dq_oe` differs from the reference model that the bench runs alongside the design. A corrupted transfer request shows up on `xfer_valid` or its fields on the clock after the transfer's column-strobe fall. Because the comparison runs on every clock, a fault is reported within one clock of becoming visible. Faults confined to unread array words are reported when a directed read-back reaches them.

// File: rtl/vdram_pkg.sv
package vdram_pkg;

  typedef enum logic [2:0] {
    CYC_IDLE,
    CYC_PLAIN,
    CYC_WPB_CUT,
    CYC_WPB_HELD,
    CYC_REGLOAD,
    CYC_XFER,
    CYC_REFRESH
  } cyc_e;

  // Cycle type from strobe levels seen at the row-strobe falling edge.
  function automatic cyc_e classify(input logic cas_n, input logic trg_n,
                                    input logic wel_n, input logic weu_n,
                                    input logic dsf);
    cyc_e c;
    if (!cas_n)                 c = CYC_REFRESH;
    else if (!trg_n)            c = CYC_XFER;
    else if (!wel_n || !weu_n)  c = dsf ? CYC_WPB_HELD : CYC_WPB_CUT;
    else                        c = dsf ? CYC_REGLOAD : CYC_PLAIN;
    return c;
  endfunction

  function automatic logic touches_array(input cyc_e c);
    return (c == CYC_PLAIN) || (c == CYC_WPB_CUT) || (c == CYC_WPB_HELD);
  endfunction

endpackage

// File: rtl/vdram_edge.sv
module vdram_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] fall
);
  logic [W-1:0] held;

  always_ff @(posedge clk) begin
    if (rst) held <= '1;
    else     held <= lvl;
  end

  assign fall = held & ~lvl;
endmodule

// File: rtl/vdram_decode.sv
module vdram_decode
  import vdram_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DQ_W   = 16,
  parameter int ROW_W  = 4,
  parameter int COL_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ras_fall,
  input  logic              cas_fall,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              trg_n,
  input  logic              wel_n,
  input  logic              weu_n,
  input  logic              dsf,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   dq_in,
  input  logic              xfer_ready,
  output cyc_e              cyc,
  output logic              rd_active,
  output logic              rd_stb,
  output logic              wr_en,
  output logic              wr_block,
  output logic [ROW_W-1:0]  acc_row,
  output logic [COL_W-1:0]  acc_col,
  output logic [DQ_W-1:0]   wr_mask,
  output logic [DQ_W-1:0]   wr_data,
  output logic              xfer_valid,
  output logic [ADDR_W-1:0] xfer_row,
  output logic [ADDR_W-1:0] xfer_tap,
  output logic              xfer_split
);
  localparam int HALF = DQ_W / 2;

  logic [ADDR_W-1:0] row_q;
  logic              split_q;
  logic [DQ_W-1:0]   cut_mask;
  logic [DQ_W-1:0]   held_mask;
  logic [DQ_W-1:0]   color_q;

  logic              in_page_cas;
  logic              array_acc;
  logic              wants_wr;
  logic              xfer_take;
  logic [DQ_W-1:0]   byte_en;
  logic [DQ_W-1:0]   bit_sel;

  assign in_page_cas = cas_fall & ~ras_n & ~ras_fall;
  assign array_acc   = in_page_cas & touches_array(cyc);
  assign wants_wr    = ~wel_n | ~weu_n;
  assign rd_stb      = array_acc & ~wants_wr;
  assign wr_en       = array_acc & wants_wr;
  assign wr_block    = dsf;
  assign acc_row     = row_q[ROW_W-1:0];
  assign acc_col     = addr[COL_W-1:0];
  assign byte_en     = {{(DQ_W-HALF){~weu_n}}, {HALF{~wel_n}}};
  assign xfer_take   = in_page_cas & (cyc == CYC_XFER) & ~xfer_valid;

  always_comb begin
    case (cyc)
      CYC_WPB_CUT:  bit_sel = cut_mask;
      CYC_WPB_HELD: bit_sel = held_mask;
      default:      bit_sel = '1;
    endcase
  end

  assign wr_mask = byte_en & bit_sel;
  assign wr_data = dsf ? color_q : dq_in;

  // Cycle state: fixed at row fall, cleared while the row strobe is high.
  always_ff @(posedge clk) begin
    if (rst) begin
      cyc       <= CYC_IDLE;
      row_q     <= '0;
      split_q   <= 1'b0;
      cut_mask  <= '1;
      rd_active <= 1'b0;
    end else if (ras_n) begin
      cyc       <= CYC_IDLE;
      rd_active <= 1'b0;
    end else if (ras_fall) begin
      cyc       <= classify(cas_n, trg_n, wel_n, weu_n, dsf);
      row_q     <= addr;
      split_q   <= dsf;
      cut_mask  <= dq_in;
      rd_active <= 1'b0;
    end else if (cas_fall) begin
      rd_active <= touches_array(cyc) & ~wants_wr;
    end
  end

  // Mask and color registers.
  always_ff @(posedge clk) begin
    if (rst) begin
      held_mask <= '1;
      color_q   <= '0;
    end else if (in_page_cas && cyc == CYC_REGLOAD) begin
      if (dsf) color_q   <= dq_in;
      else     held_mask <= dq_in;
    end
  end

  // Transfer request, valid/ready.
  always_ff @(posedge clk) begin
    if (rst) begin
      xfer_valid <= 1'b0;
      xfer_row   <= '0;
      xfer_tap   <= '0;
      xfer_split <= 1'b0;
    end else if (xfer_take) begin
      xfer_valid <= 1'b1;
      xfer_row   <= row_q;
      xfer_tap   <= addr;
      xfer_split <= split_q;
    end else if (xfer_valid && xfer_ready) begin
      xfer_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/vdram_array.sv
module vdram_array #(
  parameter int DQ_W     = 16,
  parameter int ROW_W    = 4,
  parameter int COL_W    = 4,
  parameter int BLK_COLS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_block,
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  input  logic [DQ_W-1:0]  wr_mask,
  input  logic [DQ_W-1:0]  wr_data,
  input  logic             rd_stb,
  output logic [DQ_W-1:0]  rd_data
);
  localparam int AW      = ROW_W + COL_W;
  localparam int DEPTH   = 1 << AW;
  localparam int BLK_LOG = $clog2(BLK_COLS);

  logic [DQ_W-1:0] mem [DEPTH];
  logic [AW-1:0]   lane_addr [BLK_COLS];
  logic            lane_on   [BLK_COLS];

  for (genvar k = 0; k < BLK_COLS; k++) begin : g_lane
    if (BLK_LOG == 0) begin : g_single
      assign lane_addr[k] = {row, col};
    end else begin : g_group
      assign lane_addr[k] = wr_block ? {row, col[COL_W-1:BLK_LOG], BLK_LOG'(k)}
                                     : {row, col};
    end
    assign lane_on[k] = wr_en & (wr_block | (k == 0));
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < BLK_COLS; k++) begin
      if (lane_on[k])
        mem[lane_addr[k]] <= (mem[lane_addr[k]] & ~wr_mask) | (wr_data & wr_mask);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (rd_stb) rd_data <= mem[{row, col}];
  end
endmodule

// File: rtl/vdram_rport.sv
module vdram_rport
  import vdram_pkg::*;
#(
  parameter int ADDR_W   = 9,
  parameter int DQ_W     = 16,
  parameter int ROW_W    = 4,
  parameter int COL_W    = 4,
  parameter int BLK_COLS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              trg_n,
  input  logic              wel_n,
  input  logic              weu_n,
  input  logic              dsf,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   dq_in,
  output logic [DQ_W-1:0]   dq_out,
  output logic              dq_oe,
  output logic              xfer_valid,
  input  logic              xfer_ready,
  output logic [ADDR_W-1:0] xfer_row,
  output logic [ADDR_W-1:0] xfer_tap,
  output logic              xfer_split
);
  logic [1:0]       falls;
  cyc_e             cyc_w;
  logic             rd_active_w;
  logic             rd_stb_w;
  logic             wr_en_w;
  logic             wr_block_w;
  logic [ROW_W-1:0] row_w;
  logic [COL_W-1:0] col_w;
  logic [DQ_W-1:0]  wr_mask_w;
  logic [DQ_W-1:0]  wr_data_w;

  vdram_edge #(.W(2)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  ({ras_n, cas_n}),
    .fall (falls)
  );

  vdram_decode #(
    .ADDR_W(ADDR_W), .DQ_W(DQ_W), .ROW_W(ROW_W), .COL_W(COL_W)
  ) u_dec (
    .clk        (clk),
    .rst        (rst),
    .ras_fall   (falls[1]),
    .cas_fall   (falls[0]),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .trg_n      (trg_n),
    .wel_n      (wel_n),
    .weu_n      (weu_n),
    .dsf        (dsf),
    .addr       (addr),
    .dq_in      (dq_in),
    .xfer_ready (xfer_ready),
    .cyc        (cyc_w),
    .rd_active  (rd_active_w),
    .rd_stb     (rd_stb_w),
    .wr_en      (wr_en_w),
    .wr_block   (wr_block_w),
    .acc_row    (row_w),
    .acc_col    (col_w),
    .wr_mask    (wr_mask_w),
    .wr_data    (wr_data_w),
    .xfer_valid (xfer_valid),
    .xfer_row   (xfer_row),
    .xfer_tap   (xfer_tap),
    .xfer_split (xfer_split)
  );

  vdram_array #(
    .DQ_W(DQ_W), .ROW_W(ROW_W), .COL_W(COL_W), .BLK_COLS(BLK_COLS)
  ) u_arr (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en_w),
    .wr_block (wr_block_w),
    .row      (row_w),
    .col      (col_w),
    .wr_mask  (wr_mask_w),
    .wr_data  (wr_data_w),
    .rd_stb   (rd_stb_w),
    .rd_data  (dq_out)
  );

  assign dq_oe = rd_active_w & ~cas_n & ~trg_n;
endmodule

// File: rtl/vdram_rport_chk.sv
module vdram_rport_chk
  import vdram_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              ras_n,
  input logic              dq_oe,
  input logic              xfer_valid,
  input logic              xfer_ready,
  input logic [ADDR_W-1:0] xfer_row,
  input logic [ADDR_W-1:0] xfer_tap,
  input cyc_e              cyc,
  input logic              arr_we
);
  p_oe_access_only_r9: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> (cyc inside {CYC_PLAIN, CYC_WPB_CUT, CYC_WPB_HELD}));

  p_no_oe_xfer_refresh_r2: assert property (@(posedge clk) disable iff (rst)
    (cyc == CYC_XFER || cyc == CYC_REFRESH) |-> !dq_oe);

  p_write_access_only_r4: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> (cyc inside {CYC_PLAIN, CYC_WPB_CUT, CYC_WPB_HELD}));

  p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && !xfer_ready) |=> (xfer_valid && $stable(xfer_tap) && $stable(xfer_row)));

  p_req_origin_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(xfer_valid) |-> ($past(cyc) == CYC_XFER));

  p_oe_off_row_high_r12: assert property (@(posedge clk) disable iff (rst)
    $past(ras_n) |-> !dq_oe);
endmodule

bind vdram_rport vdram_rport_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ras_n      (ras_n),
  .dq_oe      (dq_oe),
  .xfer_valid (xfer_valid),
  .xfer_ready (xfer_ready),
  .xfer_row   (xfer_row),
  .xfer_tap   (xfer_tap),
  .cyc        (cyc_w),
  .arr_we     (wr_en_w)
);

// File: tb/vdram_rport_tb.sv
module vdram_rport_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ras_n = 1'b1, cas_n = 1'b1, trg_n = 1'b1;
  logic        wel_n = 1'b1, weu_n = 1'b1, dsf = 1'b0;
  logic [8:0]  addr = '0;
  logic [15:0] dq_in = '0;
  logic        xfer_ready = 1'b0;
  logic [15:0] dq_out;
  logic        dq_oe, xfer_valid, xfer_split;
  logic [8:0]  xfer_row, xfer_tap;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vdram_rport dut_i (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .trg_n(trg_n),
    .wel_n(wel_n), .weu_n(weu_n), .dsf(dsf), .addr(addr), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .xfer_valid(xfer_valid),
    .xfer_ready(xfer_ready), .xfer_row(xfer_row), .xfer_tap(xfer_tap),
    .xfer_split(xfer_split)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [15:0] mm [256];
  int          m_cyc;   // 0 idle 1 plain 2 cut-mask 3 held-mask 4 regload 5 xfer 6 refresh
  logic        mp_ras, mp_cas, m_rd, m_split, m_xv, m_xsplit;
  logic [8:0]  m_row, m_xrow, m_xtap;
  logic [15:0] m_cut, m_mreg, m_color, m_dout;

  initial for (int i = 0; i < 256; i++) mm[i] = '0;

  always @(posedge clk) begin
    logic rf, cf, held;
    logic [15:0] bm, d;
    int base, c;
    if (rst) begin
      mp_ras = 1; mp_cas = 1; m_cyc = 0; m_rd = 0; m_split = 0; m_row = '0;
      m_cut = '1; m_mreg = '1; m_color = '0; m_dout = '0;
      m_xv = 0; m_xrow = '0; m_xtap = '0; m_xsplit = 0;
    end else begin
      rf = mp_ras && !ras_n;
      cf = mp_cas && !cas_n;
      held = m_xv;
      if (m_xv && xfer_ready) m_xv = 0;
      if (ras_n) begin
        m_cyc = 0; m_rd = 0;
      end else if (rf) begin
        m_rd = 0; m_row = addr; m_split = dsf; m_cut = dq_in;
        if (!cas_n)                m_cyc = 6;
        else if (!trg_n)           m_cyc = 5;
        else if (!wel_n || !weu_n) m_cyc = dsf ? 3 : 2;
        else                       m_cyc = dsf ? 4 : 1;
      end else if (cf) begin
        m_rd = 0;
        base = int'(m_row[3:0]) * 16;
        if (m_cyc >= 1 && m_cyc <= 3) begin
          if (wel_n && weu_n) begin
            m_dout = mm[base + int'(addr[3:0])];
            m_rd = 1;
          end else begin
            bm = {{8{!weu_n}}, {8{!wel_n}}};
            if (m_cyc == 2) bm = bm & m_cut;
            if (m_cyc == 3) bm = bm & m_mreg;
            d = dsf ? m_color : dq_in;
            if (dsf) begin
              for (int j = 0; j < 4; j++) begin
                c = (int'(addr[3:0]) / 4) * 4 + j;
                mm[base + c] = (mm[base + c] & ~bm) | (d & bm);
              end
            end else begin
              c = int'(addr[3:0]);
              mm[base + c] = (mm[base + c] & ~bm) | (d & bm);
            end
          end
        end else if (m_cyc == 4) begin
          if (dsf) m_color = dq_in; else m_mreg = dq_in;
        end else if (m_cyc == 5 && !held) begin
          m_xv = 1; m_xrow = m_row; m_xtap = addr; m_xsplit = m_split;
        end
      end
      mp_ras = ras_n;
      mp_cas = cas_n;
    end
  end

  // Compare on every clock, away from the active edge.
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R9 dq_oe vs model", {31'd0, dq_oe}, {31'd0, m_rd && !cas_n && !trg_n});
      if (m_rd && !cas_n && !trg_n) chk("R3 dq_out vs model", {16'd0, dq_out}, {16'd0, m_dout});
      chk("R10 xfer_valid vs model", {31'd0, xfer_valid}, {31'd0, m_xv});
      if (m_xv) begin
        chk("R10 xfer_row vs model", {23'd0, xfer_row}, {23'd0, m_xrow});
        chk("R10 xfer_tap vs model", {23'd0, xfer_tap}, {23'd0, m_xtap});
        chk("R10 xfer_split vs model", {31'd0, xfer_split}, {31'd0, m_xsplit});
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    ras_n = 1; cas_n = 1; trg_n = 1; wel_n = 1; weu_n = 1; dsf = 0;
    tick(); tick();
  endtask

  task automatic dram_cyc(input logic [8:0] row, input logic rwl, input logic rwu,
                          input logic rdsf, input logic [15:0] rdq,
                          input logic [8:0] col, input logic cwl, input logic cwu,
                          input logic cdsf, input logic [15:0] cdq);
    ras_n = 0; trg_n = 1; wel_n = rwl; weu_n = rwu; dsf = rdsf; addr = row; dq_in = rdq;
    tick(); tick();
    cas_n = 0; wel_n = cwl; weu_n = cwu; dsf = cdsf; addr = col; dq_in = cdq;
    tick(); tick();
    idle();
  endtask

  task automatic wr(input logic [8:0] row, input logic [8:0] col, input logic [15:0] data,
                    input logic wl, input logic wu);
    dram_cyc(row, 1, 1, 0, 16'h0, col, wl, wu, 0, data);
  endtask

  task automatic rd(input string tag, input logic [8:0] row, input logic [8:0] col,
                    input logic [15:0] exp);
    ras_n = 0; trg_n = 1; wel_n = 1; weu_n = 1; dsf = 0; addr = row;
    tick(); tick();
    trg_n = 0;
    tick();
    chk("R9 no oe before column fall", {31'd0, dq_oe}, 32'd0);
    cas_n = 0; addr = col;
    tick(); tick();
    chk(tag, {16'd0, dq_out}, {16'd0, exp});
    chk("R9 oe with column and trg low", {31'd0, dq_oe}, 32'd1);
    idle();
  endtask

  task automatic xfer(input logic [8:0] row, input logic [8:0] tap, input logic split);
    ras_n = 0; trg_n = 0; wel_n = 1; weu_n = 1; dsf = split; addr = row;
    tick(); tick();
    dsf = 0; cas_n = 0; addr = tap;
    tick(); tick();
    chk("R2 no oe in transfer", {31'd0, dq_oe}, 32'd0);
    idle();
  endtask

  initial begin
    #2_000_000;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rst = 1;
    repeat (3) tick();
    chk("R1 dq_oe in reset", {31'd0, dq_oe}, 32'd0);
    rst = 0;
    tick();
    chk("R1 dq_oe after reset", {31'd0, dq_oe}, 32'd0);
    chk("R1 xfer_valid after reset", {31'd0, xfer_valid}, 32'd0);

    // R3 plain read/write
    wr(9'd1, 9'd2, 16'hA5C3, 0, 0);
    rd("R3 read back word", 9'd1, 9'd2, 16'hA5C3);
    wr(9'd1, 9'd3, 16'h1234, 0, 0);

    // R12 page mode: two column falls in one row cycle
    ras_n = 0; trg_n = 1; addr = 9'd1; tick(); tick();
    trg_n = 0; cas_n = 0; addr = 9'd2; tick(); tick();
    chk("R12 page read first", {16'd0, dq_out}, 32'h0000A5C3);
    cas_n = 1; tick();
    cas_n = 0; addr = 9'd3; tick(); tick();
    chk("R12 page read second", {16'd0, dq_out}, 32'h00001234);
    idle();

    // R4 byte enables
    wr(9'd1, 9'd2, 16'hFFFF, 0, 1);
    rd("R4 low byte only", 9'd1, 9'd2, 16'hA5FF);
    wr(9'd1, 9'd2, 16'h0000, 1, 0);
    rd("R4 high byte only", 9'd1, 9'd2, 16'h00FF);

    // R5 per-cycle mask
    wr(9'd2, 9'd0, 16'h0000, 0, 0);
    dram_cyc(9'd2, 0, 0, 0, 16'h0F0F, 9'd0, 0, 0, 0, 16'hFFFF);
    rd("R5 per-cycle mask write", 9'd2, 9'd0, 16'h0F0F);

    // R7 load mask register, R6 stored mask
    dram_cyc(9'd0, 1, 1, 1, 16'h0, 9'd0, 1, 1, 0, 16'hF00F);
    dram_cyc(9'd2, 0, 0, 1, 16'h0, 9'd0, 0, 0, 0, 16'h0000);
    rd("R6 R7 stored mask clear", 9'd2, 9'd0, 16'h0F00);
    dram_cyc(9'd2, 0, 0, 1, 16'h0, 9'd0, 0, 0, 0, 16'hFFFF);
    rd("R6 stored mask persists", 9'd2, 9'd0, 16'hFF0F);

    // R8 block write with color register
    dram_cyc(9'd0, 1, 1, 1, 16'h0, 9'd0, 1, 1, 1, 16'h5A5A);
    wr(9'd3, 9'd3, 16'h2222, 0, 0);
    for (int k = 4; k < 8; k++) wr(9'd3, 9'(k), 16'h0000, 0, 0);
    wr(9'd3, 9'd8, 16'h1111, 0, 0);
    dram_cyc(9'd3, 1, 1, 0, 16'h0, 9'd6, 0, 0, 1, 16'hFFFF);
    rd("R8 block col4", 9'd3, 9'd4, 16'h5A5A);
    rd("R8 block col7", 9'd3, 9'd7, 16'h5A5A);
    rd("R8 outside group above", 9'd3, 9'd8, 16'h1111);
    rd("R8 outside group below", 9'd3, 9'd3, 16'h2222);
    dram_cyc(9'd3, 0, 1, 0, 16'h00F0, 9'd5, 0, 1, 1, 16'h0);
    rd("R8 block honours masks", 9'd3, 9'd5, 16'h5A5A);

    // R10 transfer request, R11 back-pressure
    xfer(9'd7, 9'h1AB, 1);
    chk("R10 valid", {31'd0, xfer_valid}, 32'd1);
    chk("R10 row", {23'd0, xfer_row}, 32'd7);
    chk("R10 tap", {23'd0, xfer_tap}, 32'h1AB);
    chk("R10 split", {31'd0, xfer_split}, 32'd1);
    xfer(9'd9, 9'h055, 0);
    chk("R11 pending kept tap", {23'd0, xfer_tap}, 32'h1AB);
    chk("R11 pending kept row", {23'd0, xfer_row}, 32'd7);
    xfer_ready = 1; tick();
    xfer_ready = 0;
    chk("R11 cleared after ready", {31'd0, xfer_valid}, 32'd0);

    // R2 refresh: column before row, no access, no oe
    trg_n = 0; wel_n = 0; weu_n = 0; dq_in = 16'hFFFF; addr = 9'd2;
    cas_n = 0; tick();
    ras_n = 0; addr = 9'd1; tick(); tick();
    chk("R2 no oe in refresh", {31'd0, dq_oe}, 32'd0);
    idle();
    rd("R2 refresh left array alone", 9'd1, 9'd2, 16'h00FF);

    // R12 column fall while row strobe high
    wel_n = 0; weu_n = 0; dq_in = 16'hFFFF; addr = 9'd2; cas_n = 0; tick();
    cas_n = 1; tick();
    idle();
    rd("R12 column without row ignored", 9'd1, 9'd2, 16'h00FF);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule